// File: doc/BRIEF.md
# Filtered Record Sum Accumulator

The block walks a table of fixed-format records stored in a synchronous single-port memory, one record at a time. Each record is four 32-bit words: a salesperson identifier, a location code, a salary and a sales amount. The block checks each record's location code against a key. When the code matches, it adds that record's sales amount to a running sum. The sum is kept in a local scratch register for the whole scan. The memory is never updated for each match.

After the last record has been examined, the block reads the dedicated total word and then overwrites it with the scratch sum. That overwrite is the only memory write of the run. A host loads the key and the record count, pulses start, and waits for the one-cycle done pulse. The busy flag is high while a scan is in progress, and a sticky overflow flag reports any carry out of the 32-bit sum.

Top module: `rec_filter_sum`

## Requirements
- R1: Out of reset busy_o, done_o, mem_re_o, mem_we_o and ovf_o are all low.
- R2: Record r occupies addresses 4*r to 4*r+3, in this order: identifier, location, salary, sales. The total word sits at the top address of the memory space (all address bits set, 1023 by default).
- R3: A record's sales word is added to the sum only when bits 15:0 of its location word equal key_i. Bits 31:16 of the location word are ignored.
- R4: The sum is cleared when a start is accepted, so the result of a run never depends on a previous run.
- R5: Each run performs exactly one memory write, to the total address, carrying the final sum. Every record word is left unchanged.
- R6: The sum wraps modulo 2^32. ovf_o goes high on the first carry out and stays high until the next accepted start clears it.
- R7: A record count of zero still produces one write of the value 0 to the total address.
- R8: A start pulse while busy_o is high is ignored. The running scan and its result are unaffected.
- R9: done_o is high for exactly one cycle, in the cycle after the total write. busy_o is high from the cycle after an accepted start through the write cycle, and low when done_o is high.
- R10: key_i and count_i are captured when start is accepted. Changing them during a scan has no effect on that scan.
- R11: Memory read data is used one cycle after the read is issued. mem_re_o and mem_we_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| key_i | input | 16 | Location code to match |
| count_i | input | 8 | Number of records to scan |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse after the total write |
| ovf_o | output | 1 | Sticky sum overflow |
| mem_re_o | output | 1 | Memory read enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 10 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid one cycle after the read |

## Verification
The hardest state to reach from the ports is a start pulse that arrives in the middle of a scan, together with a new key and count, while the scan is between a location compare and its sales fetch. The bench issues such a pulse a few cycles after an accepted start and expects the first run's total and a single write. Sum wrap-around is reached only with large sales values on several matching records, so one run loads sales near 2^32 to force a carry. Location words with random upper halves check that only the low 16 bits take part in the match.

// File: rtl/rec_filter_sum_pkg.sv
package rec_filter_sum_pkg;
  typedef enum logic [1:0] {
    SEL_LOC   = 2'd0,
    SEL_SALES = 2'd1,
    SEL_TOTAL = 2'd2
  } addr_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOC_RD  = 3'd1,
    ST_LOC_CHK = 3'd2,
    ST_SAL_RD  = 3'd3,
    ST_SAL_ADD = 3'd4,
    ST_TOT_RD  = 3'd5,
    ST_TOT_WR  = 3'd6
  } state_e;

  // word offsets inside a record; decoded by the address generator
  localparam logic [1:0] OFF_LOC   = 2'd1;
  localparam logic [1:0] OFF_SALES = 2'd3;
endpackage

// File: rtl/frs_addr_gen.sv
module frs_addr_gen
  import rec_filter_sum_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = IDX_W + 2,
  parameter logic [ADDR_W-1:0] TOTAL_ADDR = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  count_i,
  input  logic              adv_i,
  input  addr_sel_e         sel_i,
  output logic              last_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [IDX_W-1:0] idx_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      idx_q <= '0;
      cnt_q <= count_i;
    end else if (adv_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign last_o = (idx_q == cnt_q - 1'b1);

  always_comb begin
    unique case (sel_i)
      SEL_LOC:   addr_o = {idx_q, OFF_LOC};
      SEL_SALES: addr_o = {idx_q, OFF_SALES};
      default:   addr_o = TOTAL_ADDR;
    endcase
  end
endmodule

// File: rtl/frs_accum.sv
module frs_accum #(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              match_o,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o
);
  logic [KEY_W-1:0]  key_q;
  logic [DATA_W-1:0] sum_q;
  logic              ovf_q;
  logic [DATA_W:0]   add_res;

  assign add_res = {1'b0, sum_q} + {1'b0, rdata_i};
  assign match_o = (rdata_i[KEY_W-1:0] == key_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else if (load_i) begin
      key_q <= key_i;
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else if (add_i) begin
      sum_q <= add_res[DATA_W-1:0];
      ovf_q <= ovf_q | add_res[DATA_W];
    end
  end

  assign sum_o = sum_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import rec_filter_sum_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      zero_cnt_i,
  input  logic      last_i,
  input  logic      match_i,
  output logic      load_o,
  output logic      add_o,
  output logic      adv_o,
  output addr_sel_e sel_o,
  output logic      re_o,
  output logic      we_o,
  output logic      busy_o,
  output logic      done_o
);
  state_e state_q, state_d;
  logic   done_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    add_o   = 1'b0;
    adv_o   = 1'b0;
    sel_o   = SEL_LOC;
    re_o    = 1'b0;
    we_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = zero_cnt_i ? ST_TOT_RD : ST_LOC_RD;
      end
      ST_LOC_RD: begin
        re_o    = 1'b1;
        state_d = ST_LOC_CHK;
      end
      ST_LOC_CHK: begin
        if (match_i) state_d = ST_SAL_RD;
        else if (last_i) state_d = ST_TOT_RD;
        else begin
          adv_o   = 1'b1;
          state_d = ST_LOC_RD;
        end
      end
      ST_SAL_RD: begin
        sel_o   = SEL_SALES;
        re_o    = 1'b1;
        state_d = ST_SAL_ADD;
      end
      ST_SAL_ADD: begin
        sel_o = SEL_SALES;
        add_o = 1'b1;
        if (last_i) state_d = ST_TOT_RD;
        else begin
          adv_o   = 1'b1;
          state_d = ST_LOC_RD;
        end
      end
      ST_TOT_RD: begin
        sel_o   = SEL_TOTAL;
        re_o    = 1'b1;
        state_d = ST_TOT_WR;
      end
      ST_TOT_WR: begin
        sel_o   = SEL_TOTAL;
        we_o    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_TOT_WR);
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/rec_filter_sum.sv
module rec_filter_sum
  import rec_filter_sum_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [IDX_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ovf_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [ADDR_W-1:0] TOTAL_ADDR = '1;

  logic      load, add, adv, last, match;
  addr_sel_e sel;

  frs_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .zero_cnt_i (count_i == '0),
    .last_i     (last),
    .match_i    (match),
    .load_o     (load),
    .add_o      (add),
    .adv_o      (adv),
    .sel_o      (sel),
    .re_o       (mem_re_o),
    .we_o       (mem_we_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  frs_addr_gen #(
    .IDX_W      (IDX_W),
    .ADDR_W     (ADDR_W),
    .TOTAL_ADDR (TOTAL_ADDR)
  ) i_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .count_i (count_i),
    .adv_i   (adv),
    .sel_i   (sel),
    .last_o  (last),
    .addr_o  (mem_addr_o)
  );

  frs_accum #(
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W)
  ) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .key_i   (key_i),
    .add_i   (add),
    .rdata_i (mem_rdata_i),
    .match_o (match),
    .sum_o   (mem_wdata_o),
    .ovf_o   (ovf_o)
  );
endmodule

// File: rtl/rec_filter_sum_chk.sv
module rec_filter_sum_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              ovf_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  p_write_total_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == TOP_ADDR);

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_we_o) && !busy_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_re_o && !mem_we_o);

  p_rw_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  p_rec_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o && mem_addr_o != TOP_ADDR |-> mem_addr_o[0]);

  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && $past(ovf_o) |-> ovf_o);
endmodule

bind rec_filter_sum rec_filter_sum_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ovf_o      (ovf_o),
  .mem_re_o   (mem_re_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/test_rec_filter_sum.sv
`timescale 1ns/1ps
module test_rec_filter_sum;
  localparam int MEM_N = 1024;
  localparam int TOT   = MEM_N - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] key = '0;
  logic [7:0]  count = '0;
  logic        busy, done, ovf, re, we;
  logic [9:0]  addr;
  logic [31:0] wdata, rdata;

  logic [31:0] mem  [MEM_N];
  logic [31:0] shad [MEM_N];
  int          wr_cnt = 0;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rec_filter_sum i_rec_filter_sum (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key), .count_i(count),
    .busy_o(busy), .done_o(done), .ovf_o(ovf), .mem_re_o(re), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (re) rdata <= mem[addr];
    if (we) begin
      mem[addr] <= wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] k, input int n,
                                output logic [31:0] s, output logic o);
    logic [32:0] t;
    s = '0; o = 1'b0;
    for (int r = 0; r < n; r++)
      if (mem[4*r+1][15:0] == k) begin
        t = {1'b0, s} + {1'b0, mem[4*r+3]};
        s = t[31:0];
        o = o | t[32];
      end
  endfunction

  task automatic fill(input int n, input logic big);
    logic [15:0] locs [3];
    locs[0] = 16'h1234; locs[1] = 16'h00aa; locs[2] = 16'h5555;
    for (int r = 0; r < n; r++) begin
      mem[4*r]   = $urandom;
      mem[4*r+1] = {$urandom_range(65535, 0) & 32'hffff, locs[$urandom_range(2, 0)]};
      mem[4*r+2] = $urandom;
      mem[4*r+3] = big ? ($urandom | 32'hc000_0000) : $urandom_range(100000, 0);
    end
    mem[TOT] = 32'hdead_beef;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // runs one scan; interrupt pulses a second start while busy (R8, R10)
  task automatic run(input string tag, input logic [15:0] k, input int n, input logic interrupt);
    logic [31:0] es;
    logic        eo;
    int          cyc;
    int          w0;
    logic        same;
    for (int i = 0; i < MEM_N; i++) shad[i] = mem[i];
    model(k, n, es, eo);
    w0 = wr_cnt;
    @(negedge clk);
    key = k; count = n[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R9 busy after start"}, {31'b0, busy}, 32'd1);
    if (interrupt) begin
      repeat (3) @(negedge clk);
      key = k ^ 16'hffff; count = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({tag, " R8 busy kept"}, {31'b0, busy}, 32'd1);
    end
    key = ~k; count = 8'd3;   // R10: ignored mid-scan
    wait_done(cyc);
    check({tag, " R9 done reached"}, {31'b0, done}, 32'd1);
    check({tag, " R9 busy low at done"}, {31'b0, busy}, 32'd0);
    check({tag, " R5 total value R3 R4"}, mem[TOT], es);
    check({tag, " R6 ovf"}, {31'b0, ovf}, {31'b0, eo});
    check({tag, " R5 single write"}, wr_cnt - w0, 32'd1);
    same = 1'b1;
    for (int i = 0; i < TOT; i++) if (mem[i] !== shad[i]) same = 1'b0;
    check({tag, " R5 records untouched"}, {31'b0, same}, 32'd1);
    @(negedge clk);
    check({tag, " R9 done one cycle"}, {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    for (int i = 0; i < MEM_N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 we/re", {30'b0, we, re}, 32'd0);
    check("R1 ovf", {31'b0, ovf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(40, 1'b0);
    run("dir R2 R3", 16'h1234, 40, 1'b0);
    run("dir R4 rerun", 16'h1234, 40, 1'b0);
    run("dir R3 nomatch", 16'h7777, 40, 1'b0);
    fill(5, 1'b0);
    run("dir R7 zero", 16'h1234, 0, 1'b0);
    fill(30, 1'b1);
    run("dir R6 wrap", 16'h00aa, 30, 1'b0);
    fill(1, 1'b0);
    mem[1] = 32'h0000_5555;
    run("dir single", 16'h5555, 1, 1'b0);
    run("dir R6 ovf cleared", 16'h5555, 1, 1'b0);
    fill(25, 1'b0);
    run("dir R8 R10 busy start", 16'h5555, 25, 1'b1);
    fill(255, 1'b0);
    run("dir max count", 16'h00aa, 255, 1'b0);
    for (int t = 0; t < 12; t++) begin
      logic [15:0] kk;
      int n;
      n = $urandom_range(60, 0);
      fill(n, t[0]);
      kk = (t % 4 == 0) ? 16'h1234 : (t % 4 == 1) ? 16'h00aa : (t % 4 == 2) ? 16'h5555 : 16'h0bad;
      run("rnd", kk, n, t % 5 == 2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule